// File: doc/BRIEF.md
# Receive Statistics Counter Unit

This block keeps the receive-side statistics of an Ethernet MAC. Each completed frame arrives as a one-cycle event that carries its outcome (accepted or discarded), whether a discard was caused by buffer overflow, and its length in bytes including the CRC. The block counts every frame, splits the count into accepted and discarded frames, and counts overflow discards on their own. A fifth counter adds up the bytes of the accepted frames. Every counter is 64 bits wide and wraps to zero on overflow.

Software does not read the live counters. A command written to the register interface copies all five live counters, in one clock edge, into a bank of snapshot registers, which are then read 32 bits at a time. A second command clears the live counters. The reason a frame is discarded is decided upstream and is not part of this block.

Top module: `rx_stat_unit`

## Requirements
- R1: After reset, all five counters and all five snapshots are zero, so every snapshot offset reads 0x00000000.
- R2: When frm_done is high for a cycle, the total count rises by one, and either the accepted count (frm_good=1) or the discarded count (frm_good=0) rises by one, so total always equals accepted plus discarded. With frm_done low, frm_good, frm_ovf and frm_len have no effect.
- R3: The overflow-discard count rises by one only for a completed frame with frm_good=0 and frm_ovf=1; frm_ovf on an accepted frame is ignored.
- R4: The byte count adds frm_len (zero-extended) for each completed accepted frame and is unchanged by discarded frames.
- R5: A write of command 0x01 to offset 0x2C copies all five live counters into the snapshots at the clock edge that samples the write; an event in that same cycle is not included. Snapshots hold their value until the next such command.
- R6: A write of command 0x02 to offset 0x2C clears all five live counters; an event in that same cycle is lost and the counters end at zero. Snapshots are not cleared.
- R7: Only bits 7:0 of a command write are decoded (bits 31:8 are ignored); any other command value, and any write to an offset other than 0x2C, has no effect.
- R8: A read with rd_en high returns its data with rd_valid high on the next cycle. Snapshot low halves are at 0x00 (total), 0x04 (accepted), 0x08 (discarded), 0x0C (overflow discards); their high halves are at 0x10, 0x14, 0x18, 0x1C; the byte count low half is at 0x3C and high half at 0x40. Any other offset reads zero.
- R9: Counters are 64 bits: carries from bit 31 appear in the high half, and a counter wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_done | input | 1 | One-cycle pulse: a frame has finished |
| frm_good | input | 1 | Frame accepted (1) or discarded (0) |
| frm_ovf | input | 1 | Discard was caused by buffer overflow |
| frm_len | input | LEN_W (16) | Frame length in bytes including CRC |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W (8) | Register read byte offset |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | rd_data is valid for the read of the previous cycle |

## Verification
The assertions check on every cycle that the total count equals accepted plus discarded, that the overflow and byte counters only move together with the discarded and accepted counters, that a clear command leaves all counters at zero, and that a snapshot either copies the previous live value on a strobe or stays stable. Only the bench scenarios show the actual values against a model: the register offsets and the halves they return, the same-cycle collisions of an event with a strobe or a clear, the ignored command values and upper data bits, and the carry of the byte counter past 32 bits after tens of thousands of maximum-length frames.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  // Counter slots, in the order of the register offsets.
  localparam int unsigned IDX_TOTAL = 0;
  localparam int unsigned IDX_GOOD  = 1;
  localparam int unsigned IDX_BAD   = 2;
  localparam int unsigned IDX_OVF   = 3;
  localparam int unsigned IDX_OCT   = 4;
  localparam int unsigned NUM_CNT   = 5;

  localparam int unsigned CMD_OFS    = 32'h2C;
  localparam logic [7:0]  CMD_STROBE = 8'h01;
  localparam logic [7:0]  CMD_CLEAR  = 8'h02;

  function automatic int unsigned lo_ofs(input int unsigned idx);
    return (idx == IDX_OCT) ? 32'h3C : idx * 4;
  endfunction

  function automatic int unsigned hi_ofs(input int unsigned idx);
    return (idx == IDX_OCT) ? 32'h40 : 32'h10 + idx * 4;
  endfunction
endpackage

// File: rtl/rxs_cmd_decode.sv
module rxs_cmd_decode
  import rxs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              strobe,
  output logic              clear
);
  logic       hit;
  logic [7:0] code;
  logic       unused_hi;

  assign hit       = wr_en && (wr_addr == ADDR_W'(CMD_OFS));
  assign code      = wr_data[7:0];
  assign unused_hi = ^wr_data[31:8];

  assign strobe = hit && (code == CMD_STROBE);
  assign clear  = hit && (code == CMD_CLEAR);
endmodule

// File: rtl/rxs_counter.sv
module rxs_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc_en,
  input  logic [W-1:0] inc_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (inc_en) cnt <= cnt + inc_val;
  end
endmodule

// File: rtl/rxs_snapshot.sv
module rxs_snapshot #(
  parameter int W = 64,
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] live [N],
  output logic [W-1:0] snap [N]
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rst)       snap[i] <= '0;
      else if (load) snap[i] <= live[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R5: strobe copies the value the live counter held at that edge
    a_r5_snap_copy: assert property (@(posedge clk) disable iff (rst)
      $past(load) |-> snap[g] == $past(live[g]));
    // R5: without a strobe the snapshot holds
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (rst)
      !$past(load) |-> $stable(snap[g]));
  end
endmodule

// File: rtl/rxs_readmux.sv
module rxs_readmux
  import rxs_pkg::*;
#(
  parameter int W      = 64,
  parameter int N      = 5,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [W-1:0]      snap [N],
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  logic [31:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_addr == ADDR_W'(lo_ofs(i))) sel = 32'(64'(snap[i]));
      if (rd_addr == ADDR_W'(hi_ofs(i))) sel = 32'(64'(snap[i]) >> 32);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end
endmodule

// File: rtl/rx_stat_unit.sv
module rx_stat_unit
  import rxs_pkg::*;
#(
  parameter int CNT_W  = 64,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frm_done,
  input  logic              frm_good,
  input  logic              frm_ovf,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid
);
  localparam int N = NUM_CNT;

  logic             strobe, clear;
  logic [N-1:0]     inc_en;
  logic [CNT_W-1:0] inc_val [N];
  logic [CNT_W-1:0] live    [N];
  logic [CNT_W-1:0] snap    [N];

  rxs_cmd_decode #(.ADDR_W(ADDR_W)) u_cmd (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .strobe(strobe), .clear(clear)
  );

  // Per-slot increment conditions
  always_comb begin
    inc_en[IDX_TOTAL] = frm_done;
    inc_en[IDX_GOOD]  = frm_done &&  frm_good;
    inc_en[IDX_BAD]   = frm_done && !frm_good;
    inc_en[IDX_OVF]   = frm_done && !frm_good && frm_ovf;
    inc_en[IDX_OCT]   = frm_done &&  frm_good;
    for (int i = 0; i < N; i++) inc_val[i] = CNT_W'(1);
    inc_val[IDX_OCT] = CNT_W'(frm_len);
  end

  for (genvar g = 0; g < N; g++) begin : g_cnt
    rxs_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(clear),
      .inc_en(inc_en[g]), .inc_val(inc_val[g]), .cnt(live[g])
    );
  end

  rxs_snapshot #(.W(CNT_W), .N(N)) u_snap (
    .clk(clk), .rst(rst), .load(strobe), .live(live), .snap(snap)
  );

  rxs_readmux #(.W(CNT_W), .N(N), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .snap(snap), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R2: total equals accepted plus discarded
  a_r2_total_sum: assert property (@(posedge clk) disable iff (rst)
    live[IDX_TOTAL] == live[IDX_GOOD] + live[IDX_BAD]);
  // R6: a clear command leaves every counter at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
    $past(clear) |-> (live[IDX_TOTAL] == '0 && live[IDX_GOOD] == '0 &&
                      live[IDX_BAD] == '0 && live[IDX_OVF] == '0 &&
                      live[IDX_OCT] == '0));
  // R3: overflow count only moves together with the discarded count
  a_r3_ovf_with_bad: assert property (@(posedge clk) disable iff (rst)
    (!$past(clear) && live[IDX_OVF] != $past(live[IDX_OVF]))
      |-> live[IDX_BAD] != $past(live[IDX_BAD]));
  // R4: byte count only moves together with the accepted count
  a_r4_oct_with_good: assert property (@(posedge clk) disable iff (rst)
    (!$past(clear) && live[IDX_OCT] != $past(live[IDX_OCT]))
      |-> live[IDX_GOOD] != $past(live[IDX_GOOD]));
endmodule

// File: tb/rx_stat_unit_bench.sv
module rx_stat_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frm_done = 0, frm_good = 0, frm_ovf = 0;
  logic [15:0] frm_len = '0;
  logic        wr_en = 0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [63:0] m [5];   // model live counters
  logic [63:0] s [5];   // model snapshots
  logic [31:0] exp_q [$];
  string       tag_q [$];

  rx_stat_unit u_rx_stat_unit (
    .clk(clk), .rst(rst), .frm_done(frm_done), .frm_good(frm_good),
    .frm_ovf(frm_ovf), .frm_len(frm_len), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_at(input logic [7:0] a);
    case (a)
      8'h00: return s[0][31:0];   8'h10: return s[0][63:32];
      8'h04: return s[1][31:0];   8'h14: return s[1][63:32];
      8'h08: return s[2][31:0];   8'h18: return s[2][63:32];
      8'h0C: return s[3][31:0];   8'h1C: return s[3][63:32];
      8'h3C: return s[4][31:0];   8'h40: return s[4][63:32];
      default: return 32'h0;
    endcase
  endfunction

  // One cycle of stimulus, model updated per R2-style rules in the requirements
  task automatic cycle(input logic d, input logic g, input logic o,
                       input logic [15:0] l, input logic we,
                       input logic [7:0] wa, input logic [31:0] wd);
    logic [7:0] code;
    frm_done = d; frm_good = g; frm_ovf = o; frm_len = l;
    wr_en = we; wr_addr = wa; wr_data = wd;
    @(posedge clk);
    code = (we && wa == 8'h2C) ? wd[7:0] : 8'h00;
    if (code == 8'h01) for (int i = 0; i < 5; i++) s[i] = m[i];
    if (d) begin
      m[0] += 1;
      if (g) begin m[1] += 1; m[4] += 64'(l); end
      else begin m[2] += 1; if (o) m[3] += 1; end
    end
    if (code == 8'h02) for (int i = 0; i < 5; i++) m[i] = '0;
    @(negedge clk);
    frm_done = 0; frm_good = 0; frm_ovf = 0; frm_len = '0;
    wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic frame(input logic g, input logic o, input logic [15:0] l);
    cycle(1'b1, g, o, l, 1'b0, 8'h00, 32'h0);
  endtask

  task automatic cmd(input logic [7:0] a, input logic [31:0] v);
    cycle(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, a, v);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    exp_q.push_back(exp_at(a));
    tag_q.push_back(tag);
    rd_en = 1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0; rd_addr = '0;
  endtask

  task automatic rd_all(input string tag);
    logic [7:0] offs [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10,
                              8'h14, 8'h18, 8'h1C, 8'h3C, 8'h40};
    for (int i = 0; i < 10; i++) rd(offs[i], tag);
  endtask

  // Monitor: compares each returned read against the queued expectation
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R8 unexpected read data: actual %08h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %08h expected %08h", t, rd_data, e);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin m[i] = '0; s[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state
    rd_all("R1 reset snapshot");
    cmd(8'h2C, 32'h1);
    rd_all("R1 reset live");

    // R2/R3/R4: mixed frames; frm_done low is ignored
    frame(1, 0, 16'd64);
    frame(0, 1, 16'd128);
    frame(0, 0, 16'd70);
    frame(1, 1, 16'd1518);   // overflow flag on accepted frame is ignored (R3)
    frame(0, 1, 16'd9000);
    cycle(0, 1, 1, 16'd500, 0, 8'h00, 32'h0);  // no frm_done (R2)
    frame(1, 0, 16'd100);
    // R5: snapshot still old before strobe
    rd(8'h00, "R5 hold before strobe");
    rd(8'h3C, "R5 hold before strobe");
    cmd(8'h2C, 32'h1);
    rd_all("R2 R3 R4 after strobe");

    // R5: event in the strobe cycle is excluded
    cycle(1, 1, 0, 16'd200, 1, 8'h2C, 32'h1);
    rd_all("R5 same-cycle event excluded");
    cmd(8'h2C, 32'h1);
    rd_all("R5 event counted on next strobe");

    // R7: ignored command values and offsets
    frame(0, 1, 16'd60);
    cmd(8'h2C, 32'h3);
    cmd(8'h2C, 32'h0);
    cmd(8'h2C, 32'hFF);
    cmd(8'h28, 32'h1);
    cmd(8'h28, 32'h2);
    rd(8'h08, "R7 no strobe from ignored writes");
    rd(8'h0C, "R7 no strobe from ignored writes");
    cmd(8'h2C, 32'hABCD_0101);        // upper bits ignored: acts as strobe
    rd_all("R7 upper bits ignored, no clear happened");

    // R6: clear with a same-cycle event; snapshots retained
    cycle(1, 1, 0, 16'd300, 1, 8'h2C, 32'h0000_0002);
    rd_all("R6 snapshots kept after clear");
    cmd(8'h2C, 32'h1);
    rd_all("R6 cleared and event lost");

    // R8: unmapped offsets read zero
    frame(1, 0, 16'd80);
    cmd(8'h2C, 32'h1);
    rd(8'h20, "R8 unmapped");
    rd(8'h2C, "R8 unmapped");
    rd(8'h44, "R8 unmapped");
    rd(8'h02, "R8 unmapped");
    rd(8'h04, "R8 mapped accepted count");

    // R9: byte counter carries into the high half
    cmd(8'h2C, 32'h2);
    for (int i = 0; i < 65540; i++) frame(1, 0, 16'hFFFF);
    frame(0, 1, 16'd64);
    cmd(8'h2C, 32'h1);
    rd(8'h3C, "R9 octet low half");
    rd(8'h40, "R9 octet high half");
    rd(8'h04, "R9 accepted low half");
    rd(8'h00, "R9 total low half");
    rd(8'h0C, "R9 overflow count");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R8 missing read data: actual %0d pending expected 0", exp_q.size());
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule